// File: doc/BRIEF.md
# Indirect Memory Access Port

This block is a byte-wide I/O slave that gives a host access to a large local memory space through a small register window. The host loads a local address pointer, writes or reads one of four data port registers, and each such access turns into a single byte access to local memory. After every completed access the pointer moves on by one. This lets a host stream through a whole memory region using one repeated I/O address.

The memory address is built from two fields. Two bits of the bank register form the top of a 17-bit address, and the 15-bit pointer forms the rest. A third bank bit chooses which of two target memories is used: SRAM or Flash. A fourth bank bit widens the window from 16 to 40 bytes, which exposes 24 extra byte registers. Only the low six host address bits are decoded, so the whole map repeats throughout the host I/O space.

Toward each memory the block drives its own request line. The address, write flag and write byte are shared by both memories. Each memory answers with its own acknowledge and read byte. The host holds an access until the port reports it ready, and the port completes the access on that clock edge.

Top module: `iap_port`

## Requirements
- R1: After reset, the configuration register, the bank register, the pointer and all extension registers are zero. The window is therefore 16 bytes and SRAM is selected.
- R2: Decode uses only host_addr[5:0], so every register aliases across the higher address bits. While host_ce is low, the block does none of the following: assert host_ready, raise a memory request, or change any state.
- R3: The register map is: offset 0 is the configuration byte; offset 1 is the bank register; offset 2 is pointer bits 7:0; offset 3 is pointer bits 14:8 in bits 6:0. Offset 3 bit 7 reads 0 and is not stored. Offsets 8 to 15 read 0 and ignore writes. Register accesses complete in the cycle they are presented, with host_ready high at once.
- R4: When bank bit 2 is clear, offsets 16 to 39 read 0 and ignore writes. When it is set, these offsets are 24 independent read/write byte registers. Offsets 40 to 63 always read 0 and ignore writes. Bank bits 7:6 and 1:0 are plain storage.
- R5: A read of any of offsets 4 to 7 requests a read of the selected memory at address {bank[4:3], pointer}. It returns that memory's byte on host_rdata, with host_ready equal to the memory's acknowledge.
- R6: Bank bit 5 selects the target: 0 means SRAM and 1 means Flash. At most one request line is high at a time, and the other memory is left untouched.
- R7: A write to offsets 4 to 7 presents host_wdata on mem_wdata with mem_we high, and the selected memory stores it at {bank[4:3], pointer}.
- R8: Each completed data port access adds 1 to the pointer. The pointer wraps from 7FFFh to 0000h, and the bank register is never changed by the increment.
- R9: A data port access keeps its request raised until the memory acknowledges. Until then host_ready stays low and the pointer does not move. For a memory that acknowledges N cycles after the first request edge, the host sees host_ready N+1 samples after presenting the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce | input | 1 | Host chip enable |
| host_rd | input | 1 | Host read, held until host_ready |
| host_wr | input | 1 | Host write, held until host_ready; takes precedence over host_rd |
| host_addr | input | 16 | Host I/O address, only bits 5:0 decoded |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid with host_ready |
| host_ready | output | 1 | Access completes at this clock edge |
| mem_addr | output | 17 | Local memory address {bank[4:3], pointer} |
| mem_we | output | 1 | Memory write flag |
| mem_wdata | output | 8 | Memory write byte |
| sram_req | output | 1 | SRAM access request |
| sram_ack | input | 1 | SRAM acknowledge |
| sram_rdata | input | 8 | SRAM read byte |
| flash_req | output | 1 | Flash access request |
| flash_ack | input | 1 | Flash acknowledge |
| flash_rdata | input | 8 | Flash read byte |

## Verification
The directed part of the bench covers several cases. It runs data port streams with memory latencies of zero, one and two cycles, which separates a correct wait-state handshake from one that completes early or late. It loads the pointer with 7FFFh and a nonzero bank field, which shows whether the increment wraps in 15 bits or spills into the bank. It writes with the Flash target selected, which shows whether the wrong memory is reached. It repeats accesses through aliased addresses, and it makes writes with chip enable low. The random part then mixes register, extension and data port accesses across all 64 offsets, with random upper address bits and random bank values. This exposes mistakes in decode boundaries and in how the window reacts to bank bit 2.

// File: rtl/iap_pkg.sv
package iap_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFS_W  = 6;

    // fixed register offsets in the base window
    localparam logic [OFS_W-1:0] OFS_CFG    = 6'd0;
    localparam logic [OFS_W-1:0] OFS_BANK   = 6'd1;
    localparam logic [OFS_W-1:0] OFS_PTR_LO = 6'd2;
    localparam logic [OFS_W-1:0] OFS_PTR_HI = 6'd3;
    localparam int unsigned DATA_FIRST = 4;
    localparam int unsigned DATA_PORTS = 4;

    // bank register field positions (the memory address depends on them)
    localparam int unsigned BANK_EXT_BIT = 2;
    localparam int unsigned BANK_HI_LSB  = 3;
    localparam int unsigned BANK_HI_W    = 2;
    localparam int unsigned BANK_DEV_BIT = 5;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CFG,
        ACC_BANK,
        ACC_PTR_LO,
        ACC_PTR_HI,
        ACC_DATA,
        ACC_EXT
    } acc_kind_e;

endpackage

// File: rtl/iap_decode.sv
module iap_decode
    import iap_pkg::*;
#(
    parameter int unsigned BASE_WIN = 16,
    parameter int unsigned EXT_REGS = 24,
    localparam int unsigned IDX_W = $clog2(EXT_REGS)
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic             ext_en,
    output acc_kind_e        kind,
    output logic [IDX_W-1:0] ext_idx
);

    localparam logic [OFS_W:0] BASE_END = (OFS_W+1)'(BASE_WIN);
    localparam logic [OFS_W:0] EXT_END  = (OFS_W+1)'(BASE_WIN + EXT_REGS);
    localparam logic [OFS_W:0] DATA_LO  = (OFS_W+1)'(DATA_FIRST);
    localparam logic [OFS_W:0] DATA_END = (OFS_W+1)'(DATA_FIRST + DATA_PORTS);

    logic [OFS_W:0] ofs_x;
    assign ofs_x = {1'b0, ofs};

    always_comb begin
        kind    = ACC_NONE;
        ext_idx = '0;
        if (ofs_x < BASE_END) begin
            if (ofs_x >= DATA_LO && ofs_x < DATA_END) begin
                kind = ACC_DATA;
            end else begin
                case (ofs)
                    OFS_CFG:    kind = ACC_CFG;
                    OFS_BANK:   kind = ACC_BANK;
                    OFS_PTR_LO: kind = ACC_PTR_LO;
                    OFS_PTR_HI: kind = ACC_PTR_HI;
                    default:    kind = ACC_NONE;
                endcase
            end
        end else if (ext_en && ofs_x < EXT_END) begin
            kind    = ACC_EXT;
            ext_idx = IDX_W'(ofs_x - BASE_END);
        end
    end

endmodule

// File: rtl/iap_mem_route.sv
module iap_mem_route
    import iap_pkg::*;
(
    input  logic              go,
    input  logic              dev_sel,
    output logic              sram_req,
    output logic              flash_req,
    input  logic              sram_ack,
    input  logic              flash_ack,
    input  logic [BYTE_W-1:0] sram_rdata,
    input  logic [BYTE_W-1:0] flash_rdata,
    output logic              ack,
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        sram_req  = go && !dev_sel;
        flash_req = go && dev_sel;
        ack       = dev_sel ? flash_ack : sram_ack;
        rdata     = dev_sel ? flash_rdata : sram_rdata;
    end

endmodule

// File: rtl/iap_ext_regs.sv
module iap_ext_regs
    import iap_pkg::*;
#(
    parameter int unsigned EXT_REGS = 24,
    localparam int unsigned IDX_W = $clog2(EXT_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] regs_q [EXT_REGS];

    for (genvar g = 0; g < EXT_REGS; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_d;

        always_comb begin
            byte_d = regs_q[g];
            if (wr_en && idx == IDX_W'(g)) begin
                byte_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= byte_d;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < EXT_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_data = regs_q[i];
            end
        end
    end

endmodule

// File: rtl/iap_port.sv
module iap_port
    import iap_pkg::*;
#(
    parameter int unsigned HOST_AW  = 16,
    parameter int unsigned PTR_W    = 15,
    parameter int unsigned EXT_REGS = 24,
    parameter int unsigned BASE_WIN = 16,
    localparam int unsigned MEM_AW  = PTR_W + BANK_HI_W,
    localparam int unsigned IDX_W   = $clog2(EXT_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_ce,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               host_ready,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic               mem_we,
    output logic [BYTE_W-1:0]  mem_wdata,
    output logic               sram_req,
    input  logic               sram_ack,
    input  logic [BYTE_W-1:0]  sram_rdata,
    output logic               flash_req,
    input  logic               flash_ack,
    input  logic [BYTE_W-1:0]  flash_rdata
);

    typedef struct packed {
        logic [BYTE_W-1:0] cfg;
        logic [BYTE_W-1:0] bank;
        logic [PTR_W-1:0]  ptr;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [OFS_W-1:0]  ofs;
    logic              addr_unused;
    logic              access;
    acc_kind_e         kind;
    logic [IDX_W-1:0]  ext_idx;
    logic              data_go;
    logic              mem_ack;
    logic [BYTE_W-1:0] mem_rdata;
    logic [BYTE_W-1:0] ext_rdata;
    logic              ext_wr;
    logic [PTR_W-1:0]  ptr_cur;
    logic [BYTE_W-1:0] bank_cur;

    assign ofs         = host_addr[OFS_W-1:0];
    assign addr_unused = ^host_addr[HOST_AW-1:OFS_W];
    assign access      = host_ce && (host_rd || host_wr);
    assign ptr_cur     = st_q.ptr;
    assign bank_cur    = st_q.bank;

    iap_decode #(
        .BASE_WIN (BASE_WIN),
        .EXT_REGS (EXT_REGS)
    ) i_decode (
        .ofs     (ofs),
        .ext_en  (st_q.bank[BANK_EXT_BIT]),
        .kind    (kind),
        .ext_idx (ext_idx)
    );

    assign data_go = access && (kind == ACC_DATA);

    iap_mem_route i_route (
        .go          (data_go),
        .dev_sel     (st_q.bank[BANK_DEV_BIT]),
        .sram_req    (sram_req),
        .flash_req   (flash_req),
        .sram_ack    (sram_ack),
        .flash_ack   (flash_ack),
        .sram_rdata  (sram_rdata),
        .flash_rdata (flash_rdata),
        .ack         (mem_ack),
        .rdata       (mem_rdata)
    );

    assign ext_wr = access && host_wr && (kind == ACC_EXT);

    iap_ext_regs #(
        .EXT_REGS (EXT_REGS)
    ) i_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ext_wr),
        .idx     (ext_idx),
        .wr_data (host_wdata),
        .rd_data (ext_rdata)
    );

    // memory side
    assign mem_addr  = {st_q.bank[BANK_HI_LSB +: BANK_HI_W], st_q.ptr};
    assign mem_we    = host_wr;
    assign mem_wdata = host_wdata;

    // host side
    always_comb begin
        host_ready = 1'b0;
        if (access) begin
            host_ready = (kind == ACC_DATA) ? mem_ack : 1'b1;
        end
    end

    always_comb begin
        case (kind)
            ACC_CFG:    host_rdata = st_q.cfg;
            ACC_BANK:   host_rdata = st_q.bank;
            ACC_PTR_LO: host_rdata = st_q.ptr[BYTE_W-1:0];
            ACC_PTR_HI: host_rdata = BYTE_W'(st_q.ptr[PTR_W-1:BYTE_W]);
            ACC_DATA:   host_rdata = mem_rdata;
            ACC_EXT:    host_rdata = ext_rdata;
            default:    host_rdata = '0;
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (access && host_wr) begin
            case (kind)
                ACC_CFG:    st_d.cfg = host_wdata;
                ACC_BANK:   st_d.bank = host_wdata;
                ACC_PTR_LO: st_d.ptr[BYTE_W-1:0] = host_wdata;
                ACC_PTR_HI: st_d.ptr[PTR_W-1:BYTE_W] = host_wdata[PTR_W-BYTE_W-1:0];
                default:    st_d = st_q;
            endcase
        end
        if (data_go && mem_ack) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/iap_port_chk.sv
module iap_port_chk
    import iap_pkg::*;
#(
    parameter int unsigned PTR_W   = 15,
    parameter int unsigned WIN_MAX = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ce,
    input logic              host_rd,
    input logic              host_wr,
    input logic [OFS_W-1:0]  host_ofs,
    input logic              host_ready,
    input logic [BYTE_W-1:0] host_rdata,
    input logic              sram_req,
    input logic              sram_ack,
    input logic              flash_req,
    input logic              flash_ack,
    input logic [PTR_W-1:0]  ptr_q,
    input logic [BYTE_W-1:0] bank_q
);

    logic data_done;
    logic waiting;
    assign data_done = (sram_req && sram_ack) || (flash_req && flash_ack);
    assign waiting   = (sram_req && !sram_ack) || (flash_req && !flash_ack);

    // R6
    target_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_req, flash_req}));

    // R2
    ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ce |-> (!sram_req && !flash_req && !host_ready));

    // R8
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R8
    bank_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_done |=> $stable(bank_q));

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |=> $stable(ptr_q));

    // R4
    window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ce && host_rd && !host_wr && {1'b0, host_ofs} >= (OFS_W+1)'(WIN_MAX))
            |-> (host_ready && host_rdata == '0));

endmodule

bind iap_port iap_port_chk #(
    .PTR_W   (PTR_W),
    .WIN_MAX (BASE_WIN + EXT_REGS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ce    (host_ce),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_ofs   (ofs),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .sram_req   (sram_req),
    .sram_ack   (sram_ack),
    .flash_req  (flash_req),
    .flash_ack  (flash_ack),
    .ptr_q      (ptr_cur),
    .bank_q     (bank_cur)
);

// File: tb/test_iap_port.sv
module test_iap_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ce = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_ready;
    logic [16:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        sram_req, flash_req;
    logic        sram_ack = 1'b0, flash_ack = 1'b0;
    logic [7:0]  sram_rdata = '0, flash_rdata = '0;

    always #2 clk = ~clk;

    iap_port i_iap_port (
        .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_ready(host_ready), .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .sram_req(sram_req), .sram_ack(sram_ack), .sram_rdata(sram_rdata),
        .flash_req(flash_req), .flash_ack(flash_ack), .flash_rdata(flash_rdata)
    );

    // memory models
    logic [7:0] sram_mem  [0:131071];
    logic [7:0] flash_mem [0:131071];
    int mem_lat = 0;
    int s_cnt = 0, f_cnt = 0;

    always @(posedge clk) begin
        if (!sram_req) begin
            sram_ack <= 1'b0; s_cnt <= 0;
        end else if (sram_ack) begin
            sram_ack <= 1'b0;
        end else if (s_cnt >= mem_lat) begin
            sram_ack   <= 1'b1;
            sram_rdata <= sram_mem[mem_addr];
            if (mem_we) sram_mem[mem_addr] <= mem_wdata;
            s_cnt <= 0;
        end else begin
            s_cnt <= s_cnt + 1;
        end
    end

    always @(posedge clk) begin
        if (!flash_req) begin
            flash_ack <= 1'b0; f_cnt <= 0;
        end else if (flash_ack) begin
            flash_ack <= 1'b0;
        end else if (f_cnt >= mem_lat) begin
            flash_ack   <= 1'b1;
            flash_rdata <= flash_mem[mem_addr];
            if (mem_we) flash_mem[mem_addr] <= mem_wdata;
            f_cnt <= 0;
        end else begin
            f_cnt <= f_cnt + 1;
        end
    end

    // bench shadow of the expected register state
    logic [7:0]  sh_cfg = '0, sh_bank = '0;
    logic [14:0] sh_ptr = '0;
    logic [7:0]  sh_ext [24];
    int n_checks = 0, n_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    function automatic logic [7:0] exp_reg(input int ofs);
        if (ofs == 0) return sh_cfg;
        if (ofs == 1) return sh_bank;
        if (ofs == 2) return sh_ptr[7:0];
        if (ofs == 3) return {1'b0, sh_ptr[14:8]};
        if (ofs >= 16 && ofs < 40 && sh_bank[2]) return sh_ext[ofs-16];
        return 8'h00;
    endfunction

    task automatic host_access(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                               output logic [7:0] rd, output int waits);
        waits = 0;
        @(negedge clk);
        host_ce = 1'b1; host_wr = wr; host_rd = !wr; host_addr = addr; host_wdata = wd;
        while (1) begin
            #1;
            if (host_ready) break;
            @(negedge clk);
            waits++;
            if (waits > 40) break;
        end
        rd = host_rdata;
        @(posedge clk);
        #1;
        host_ce = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    endtask

    task automatic do_op(input logic wr, input logic [15:0] addr, input logic [7:0] wd,
                         input int lat, input string tag);
        int ofs;
        logic [7:0] got;
        int waits;
        ofs = int'(addr[5:0]);
        if (ofs >= 4 && ofs < 8) begin
            logic        tgt;
            logic [16:0] a;
            logic [7:0]  exp_rd, other_before;
            tgt = sh_bank[5];
            a = {sh_bank[4:3], sh_ptr};
            exp_rd = tgt ? flash_mem[a] : sram_mem[a];
            other_before = tgt ? sram_mem[a] : flash_mem[a];
            mem_lat = lat;
            host_access(wr, addr, wd, got, waits);
            check(waits == lat + 1, "R9 wait states", waits, lat + 1);
            if (wr) begin
                check((tgt ? flash_mem[a] : sram_mem[a]) == wd, "R7 stored byte",
                      int'(tgt ? flash_mem[a] : sram_mem[a]), int'(wd));
            end else begin
                check(got == exp_rd, "R5 read byte", int'(got), int'(exp_rd));
            end
            check((tgt ? sram_mem[a] : flash_mem[a]) == other_before, "R6 other target untouched",
                  int'(tgt ? sram_mem[a] : flash_mem[a]), int'(other_before));
            sh_ptr = sh_ptr + 15'd1;
        end else begin
            host_access(wr, addr, wd, got, waits);
            check(waits == 0, "R3 immediate ready", waits, 0);
            if (wr) begin
                if (ofs == 0) sh_cfg = wd;
                else if (ofs == 1) sh_bank = wd;
                else if (ofs == 2) sh_ptr[7:0] = wd;
                else if (ofs == 3) sh_ptr[14:8] = wd[6:0];
                else if (ofs >= 16 && ofs < 40 && sh_bank[2]) sh_ext[ofs-16] = wd;
            end else begin
                check(got == exp_reg(ofs), tag, int'(got), int'(exp_reg(ofs)));
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin : main
        logic [15:0] ra;
        for (int i = 0; i < 131072; i++) begin
            sram_mem[i]  = 8'(i * 13 + (i >> 8));
            flash_mem[i] = 8'(i ^ (i >> 5) ^ 8'h5A);
        end
        for (int i = 0; i < 24; i++) sh_ext[i] = '0;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(!sram_req && !flash_req && !host_ready, "R1 idle outputs", {sram_req, flash_req}, 0);
        for (int o = 0; o < 4; o++) do_op(1'b0, 16'(o), 8'h00, 0, "R1 reset register");
        do_op(1'b0, 16'd20, 8'h00, 0, "R1 window closed at reset");
        do_op(1'b0, 16'd4, 8'h00, 1, "R1");   // first data read goes to SRAM at address 0

        // R2 aliasing through high address bits
        do_op(1'b1, 16'hA402, 8'h34, 0, "R2");
        do_op(1'b1, 16'h7FC3, 8'hFF, 0, "R2");
        do_op(1'b0, 16'h0043, 8'h00, 0, "R3 pointer high bit 7 reads zero");
        do_op(1'b0, 16'hFFC2, 8'h00, 0, "R2 alias read");

        // R2 chip enable low
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            host_ce = 1'b0; host_wr = 1'b1; host_addr = (k == 0) ? 16'h0001 : 16'h0005;
            host_wdata = 8'hFF;
            repeat (3) begin
                #1;
                check(!host_ready && !sram_req && !flash_req, "R2 ce low",
                      {host_ready, sram_req, flash_req}, 0);
                @(negedge clk);
            end
            host_wr = 1'b0;
        end
        do_op(1'b0, 16'd1, 8'h00, 0, "R2 bank unchanged after ce low");
        do_op(1'b0, 16'd2, 8'h00, 0, "R2 pointer unchanged after ce low");

        // R3 reserved offsets
        for (int o = 8; o < 16; o++) begin
            do_op(1'b1, 16'(o), 8'hA5, 0, "R3");
            do_op(1'b0, 16'(o), 8'h00, 0, "R3 reserved reads zero");
        end
        do_op(1'b1, 16'd0, 8'h9C, 0, "R3");
        do_op(1'b0, 16'd0, 8'h00, 0, "R3 config readback");

        // R4 window size
        do_op(1'b1, 16'd20, 8'h11, 0, "R4");
        do_op(1'b0, 16'd20, 8'h00, 0, "R4 closed window ignores write");
        do_op(1'b1, 16'd1, 8'hC7, 0, "R4");   // ext window on, storage bits set
        do_op(1'b1, 16'd20, 8'h22, 0, "R4");
        do_op(1'b1, 16'd39, 8'h33, 0, "R4");
        do_op(1'b1, 16'd16, 8'h44, 0, "R4");
        do_op(1'b0, 16'd20, 8'h00, 0, "R4 extension register");
        do_op(1'b0, 16'd39, 8'h00, 0, "R4 last extension register");
        do_op(1'b0, 16'd16, 8'h00, 0, "R4 first extension register");
        do_op(1'b1, 16'd40, 8'h55, 0, "R4");
        do_op(1'b0, 16'd40, 8'h00, 0, "R4 beyond window reads zero");
        do_op(1'b0, 16'd63, 8'h00, 0, "R4 top offset reads zero");
        do_op(1'b0, 16'd1, 8'h00, 0, "R4 storage bits kept");
        do_op(1'b1, 16'd1, 8'h00, 0, "R4");
        do_op(1'b0, 16'd39, 8'h00, 0, "R4 window closed again");

        // R5 R9 data stream from SRAM over all four ports and latencies
        do_op(1'b1, 16'd2, 8'h10, 0, "R5");
        do_op(1'b1, 16'd3, 8'h02, 0, "R5");
        for (int p = 0; p < 12; p++) do_op(1'b0, 16'(4 + p % 4), 8'h00, p % 3, "R5");
        do_op(1'b0, 16'd2, 8'h00, 0, "R8 pointer after stream");

        // R8 wrap without carry into bank
        do_op(1'b1, 16'd1, 8'h18, 0, "R8");
        do_op(1'b1, 16'd2, 8'hFF, 0, "R8");
        do_op(1'b1, 16'd3, 8'h7F, 0, "R8");
        do_op(1'b0, 16'd6, 8'h00, 2, "R8");
        do_op(1'b0, 16'd2, 8'h00, 0, "R8 wrapped pointer low");
        do_op(1'b0, 16'd3, 8'h00, 0, "R8 wrapped pointer high");
        do_op(1'b0, 16'd1, 8'h00, 0, "R8 bank unchanged by wrap");

        // R6 R7 Flash target writes
        do_op(1'b1, 16'd1, 8'h28, 0, "R6");
        for (int p = 0; p < 6; p++) do_op(1'b1, 16'(4 + p % 4), 8'(8'hE0 + p), p % 3, "R7");
        do_op(1'b1, 16'd2, 8'h00, 0, "R6");
        do_op(1'b1, 16'd3, 8'h00, 0, "R6");
        for (int p = 0; p < 6; p++) do_op(1'b0, 16'd7, 8'h00, 1, "R6");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int o;
            if ($urandom % 100 < 40) o = 4 + int'($urandom % 4);
            else o = int'($urandom % 64);
            ra = {10'($urandom), 6'(o)};
            do_op(1'($urandom), ra, 8'($urandom), int'($urandom % 3),
                  (o >= 16) ? "R4 random" : "R2/R3 random");
        end

        finish_run();
    end

endmodule